// File: doc/BRIEF.md
# Processor Status Word and Exception Entry Unit

This block owns the current processor status word and performs the state changes when the core takes an exception or returns from one. Seven request lines come in, one for each exception kind: reset, undefined instruction, software trap, instruction-fetch abort, data abort, normal interrupt and fast interrupt. The block removes the interrupt requests that the status word currently disables. It picks the highest-priority request that remains and, one clock later, shows the new status word, the vector address to load into the program counter, the status word to be saved into the target mode's bank, and the link value. A one-cycle entry pulse goes with these outputs.

The unit also handles two other operations. An exception return restores the status word and program counter from values supplied by the banked storage. A status-move writes selected bytes of the status word under a 4-bit field mask, and in User mode only the flag byte may be written. The banked registers, instruction decode and memory access are outside this block. All pins are plain control and status signals. Every output is registered and must be consumed in the cycle it is pulsed, because the block has no stream handshake and accepts no back-pressure.

Top module: `pstat_trap_unit`

## Requirements
- R1: After reset the status word is 0x000000D3: Supervisor mode 10011 in bits 4:0, interrupt-disable bit 7 set, fast-interrupt-disable bit 6 set, state bit 5 clear. entry_o, pc_load_o and every other registered output are zero.
- R2: Request line index gives the exception: 0 reset, 1 undefined, 2 software trap, 3 fetch abort, 4 data abort, 5 interrupt, 6 fast interrupt. Among the unmasked requests the winner follows the order reset > data abort > fast interrupt > interrupt > fetch abort > undefined > software trap, and its index appears on exc_id_o.
- R3: While status bit 7 is set, request 5 is ignored. While status bit 6 is set, request 6 is ignored. A request that is ignored produces no entry and leaves the status word unchanged.
- R4: The vector is base + offset. The base is 0x00000000, or 0xFFFF0000 when hi_vec_i is 1. The offsets are reset 0x00, undefined 0x04, software trap 0x08, fetch abort 0x0C, data abort 0x10, interrupt 0x18, fast interrupt 0x1C.
- R5: The cycle after an accepted request, entry_o and pc_load_o are high for that cycle. In the same cycle saved_psr_o holds the status word from before the entry, link_o holds pc_i sampled with the request, and save_mode_o holds the target mode.
- R6: The status word after entry keeps bits 31:25 and 23:8 and clears state bits 5 and 24. It sets bit 7, and sets bit 6 only for reset and fast interrupt. Mode bits 4:0 become the target mode: 10011 for reset and software trap, 11011 for undefined, 10111 for both aborts, 10010 for interrupt, 10001 for fast interrupt.
- R7: A return request loads the status word from ret_psr_i, shows ret_addr_i on next_pc_o with pc_load_o high for one cycle, and keeps entry_o low.
- R8: In any mode other than User (10000), a status-move writes byte k of mv_data_i into byte k of the status word for each set bit k of mv_mask_i. Bit 3 selects bits 31:24, bit 2 selects 23:16, bit 1 selects 15:8 and bit 0 selects 7:0.
- R9: In User mode a status-move writes only bits 31:24, and only when mask bit 3 is set. Bits 23:0 stay unchanged.
- R10: When several operations arrive in one cycle, an accepted exception wins over a return, and a return wins over a status-move. The losing operations are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req_i | input | 7 | Exception request lines, index as in R2 |
| hi_vec_i | input | 1 | Selects the high vector base |
| pc_i | input | 32 | Current program counter, captured as link value |
| ret_req_i | input | 1 | Exception return request |
| ret_psr_i | input | 32 | Saved status word to restore |
| ret_addr_i | input | 32 | Return address to restore |
| mv_req_i | input | 1 | Status-move request |
| mv_mask_i | input | 4 | Field mask of the status-move |
| mv_data_i | input | 32 | Data of the status-move |
| psr_o | output | 32 | Current status word |
| entry_o | output | 1 | One-cycle exception entry pulse |
| pc_load_o | output | 1 | next_pc_o is valid this cycle |
| next_pc_o | output | 32 | Vector or return address |
| saved_psr_o | output | 32 | Status word to store in the target bank |
| save_mode_o | output | 5 | Mode whose bank receives saved_psr_o and link_o |
| link_o | output | 32 | Link value for the target bank |
| exc_id_o | output | 3 | Index of the exception taken |

## Verification
The assertions check several properties on every cycle. At most one request is granted, and a disabled interrupt is never granted. Every entry leaves bit 7 set, clears both state bits, matches the mode bits to save_mode_o and produces a word-aligned vector. A User-mode move never touches bits 23:0, and a lone return restores the supplied word. The bench scenarios show the rest: the full priority order under mixed requests, the exact vector values for both bases, the save and link values, the byte-selective writes in privileged modes, and which operation wins when an exception, a return and a move arrive in the same cycle.

// File: rtl/pstat_pkg.sv
package pstat_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned EXC_N   = 7;
  localparam int unsigned MODE_W  = 5;
  localparam int unsigned FIELD_N = WORD_W / 8;
  localparam int unsigned FLAG_FIELD = FIELD_N - 1;

  localparam int unsigned BIT_J = 24;
  localparam int unsigned BIT_I = 7;
  localparam int unsigned BIT_F = 6;
  localparam int unsigned BIT_T = 5;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [MODE_W-1:0] mode_t;

  typedef enum logic [2:0] {
    EXC_RESET = 3'd0,
    EXC_UNDEF = 3'd1,
    EXC_SWT   = 3'd2,
    EXC_FABT  = 3'd3,
    EXC_DABT  = 3'd4,
    EXC_IRQ   = 3'd5,
    EXC_FIQ   = 3'd6
  } exc_e;

  localparam mode_t MODE_USR = 5'b10000;
  localparam mode_t MODE_FIQ = 5'b10001;
  localparam mode_t MODE_IRQ = 5'b10010;
  localparam mode_t MODE_SVC = 5'b10011;
  localparam mode_t MODE_ABT = 5'b10111;
  localparam mode_t MODE_UND = 5'b11011;
  localparam mode_t MODE_SYS = 5'b11111;

  localparam word_t RESET_STATUS = 32'h0000_00D3;

  // rank 0 is the most urgent
  function automatic exc_e prio_at(input int unsigned rank);
    case (rank)
      0: prio_at = EXC_RESET;
      1: prio_at = EXC_DABT;
      2: prio_at = EXC_FIQ;
      3: prio_at = EXC_IRQ;
      4: prio_at = EXC_FABT;
      5: prio_at = EXC_UNDEF;
      default: prio_at = EXC_SWT;
    endcase
  endfunction

  // word slot inside the vector table (slot 5 is left unused)
  function automatic logic [2:0] vec_slot(input exc_e e);
    case (e)
      EXC_RESET: vec_slot = 3'd0;
      EXC_UNDEF: vec_slot = 3'd1;
      EXC_SWT:   vec_slot = 3'd2;
      EXC_FABT:  vec_slot = 3'd3;
      EXC_DABT:  vec_slot = 3'd4;
      EXC_IRQ:   vec_slot = 3'd6;
      default:   vec_slot = 3'd7;
    endcase
  endfunction

  function automatic mode_t target_mode(input exc_e e);
    case (e)
      EXC_RESET, EXC_SWT:  target_mode = MODE_SVC;
      EXC_UNDEF:           target_mode = MODE_UND;
      EXC_FABT, EXC_DABT:  target_mode = MODE_ABT;
      EXC_IRQ:             target_mode = MODE_IRQ;
      default:             target_mode = MODE_FIQ;
    endcase
  endfunction

  function automatic logic blocks_fast(input exc_e e);
    blocks_fast = (e == EXC_RESET) || (e == EXC_FIQ);
  endfunction
endpackage

// File: rtl/pstat_trap_arb.sv
module pstat_trap_arb
  import pstat_pkg::*;
#(
  parameter int unsigned LINES = EXC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_i,
  input  logic             irq_off_i,
  input  logic             fiq_off_i,
  output logic             valid_o,
  output exc_e             id_o,
  output logic [LINES-1:0] grant_o
);
  logic [LINES-1:0] live;

  for (genvar i = 0; i < LINES; i++) begin : g_mask
    if (i == int'(EXC_IRQ)) begin : g_irq
      assign live[i] = req_i[i] & ~irq_off_i;
    end else if (i == int'(EXC_FIQ)) begin : g_fiq
      assign live[i] = req_i[i] & ~fiq_off_i;
    end else begin : g_plain
      assign live[i] = req_i[i];
    end
  end

  always_comb begin
    valid_o = 1'b0;
    id_o    = EXC_SWT;
    for (int r = int'(LINES) - 1; r >= 0; r--) begin
      if (live[prio_at(unsigned'(r))]) begin
        valid_o = 1'b1;
        id_o    = prio_at(unsigned'(r));
      end
    end
  end

  always_comb begin
    grant_o = '0;
    if (valid_o) grant_o[id_o] = 1'b1;
  end

  // R2
  grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R3
  irq_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_off_i |-> !grant_o[EXC_IRQ]);

  // R3
  fiq_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_off_i |-> !grant_o[EXC_FIQ]);

  // R2
  reset_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i[EXC_RESET] |-> (valid_o && id_o == EXC_RESET));
endmodule

// File: rtl/pstat_entry_build.sv
module pstat_entry_build
  import pstat_pkg::*;
#(
  parameter word_t LO_BASE = 32'h0000_0000,
  parameter word_t HI_BASE = 32'hFFFF_0000
) (
  input  word_t cur_i,
  input  exc_e  id_i,
  input  logic  hi_i,
  output word_t status_o,
  output word_t vec_o,
  output mode_t mode_o
);
  localparam int unsigned SLOT_SHIFT = 2;

  word_t base;
  word_t offset;

  assign base   = hi_i ? HI_BASE : LO_BASE;
  assign offset = word_t'(vec_slot(id_i)) << SLOT_SHIFT;
  assign vec_o  = base + offset;
  assign mode_o = target_mode(id_i);

  always_comb begin
    status_o        = cur_i;
    status_o[BIT_T] = 1'b0;
    status_o[BIT_J] = 1'b0;
    status_o[BIT_I] = 1'b1;
    if (blocks_fast(id_i)) status_o[BIT_F] = 1'b1;
    status_o[MODE_W-1:0] = mode_o;
  end
endmodule

// File: rtl/pstat_field_merge.sv
module pstat_field_merge
  import pstat_pkg::*;
(
  input  word_t              cur_i,
  input  word_t              wr_i,
  input  logic [FIELD_N-1:0] mask_i,
  input  logic               priv_i,
  output word_t              next_o
);
  for (genvar b = 0; b < FIELD_N; b++) begin : g_field
    localparam bit IS_FLAG = (b == FLAG_FIELD);
    logic en;
    assign en = mask_i[b] & (priv_i | IS_FLAG);
    assign next_o[b*8 +: 8] = en ? wr_i[b*8 +: 8] : cur_i[b*8 +: 8];
  end
endmodule

// File: rtl/pstat_trap_unit.sv
module pstat_trap_unit
  import pstat_pkg::*;
#(
  parameter logic [31:0] LO_BASE = 32'h0000_0000,
  parameter logic [31:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  exc_req_i,
  input  logic        hi_vec_i,
  input  logic [31:0] pc_i,
  input  logic        ret_req_i,
  input  logic [31:0] ret_psr_i,
  input  logic [31:0] ret_addr_i,
  input  logic        mv_req_i,
  input  logic [3:0]  mv_mask_i,
  input  logic [31:0] mv_data_i,
  output logic [31:0] psr_o,
  output logic        entry_o,
  output logic        pc_load_o,
  output logic [31:0] next_pc_o,
  output logic [31:0] saved_psr_o,
  output logic [4:0]  save_mode_o,
  output logic [31:0] link_o,
  output logic [2:0]  exc_id_o
);
  word_t psr_q, npc_q, spsr_q, link_q;
  mode_t smode_q;
  exc_e  id_q;
  logic  entry_q, load_q;

  logic        take;
  exc_e        win_id;
  logic [EXC_N-1:0] grant;
  word_t       entry_status, entry_vec, move_status;
  mode_t       entry_mode;
  logic        priv;

  assign priv = (psr_q[MODE_W-1:0] != MODE_USR);

  pstat_trap_arb #(.LINES(EXC_N)) arb_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (exc_req_i),
    .irq_off_i(psr_q[BIT_I]),
    .fiq_off_i(psr_q[BIT_F]),
    .valid_o  (take),
    .id_o     (win_id),
    .grant_o  (grant)
  );

  pstat_entry_build #(.LO_BASE(LO_BASE), .HI_BASE(HI_BASE)) build_i (
    .cur_i   (psr_q),
    .id_i    (win_id),
    .hi_i    (hi_vec_i),
    .status_o(entry_status),
    .vec_o   (entry_vec),
    .mode_o  (entry_mode)
  );

  pstat_field_merge merge_i (
    .cur_i (psr_q),
    .wr_i  (mv_data_i),
    .mask_i(mv_mask_i),
    .priv_i(priv),
    .next_o(move_status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psr_q   <= RESET_STATUS;
      entry_q <= 1'b0;
      load_q  <= 1'b0;
      npc_q   <= '0;
      spsr_q  <= '0;
      link_q  <= '0;
      smode_q <= '0;
      id_q    <= EXC_RESET;
    end else begin
      entry_q <= 1'b0;
      load_q  <= 1'b0;
      if (take) begin
        psr_q   <= entry_status;
        entry_q <= 1'b1;
        load_q  <= 1'b1;
        npc_q   <= entry_vec;
        spsr_q  <= psr_q;
        link_q  <= pc_i;
        smode_q <= entry_mode;
        id_q    <= win_id;
      end else if (ret_req_i) begin
        psr_q  <= ret_psr_i;
        load_q <= 1'b1;
        npc_q  <= ret_addr_i;
      end else if (mv_req_i) begin
        psr_q <= move_status;
      end
    end
  end

  assign psr_o       = psr_q;
  assign entry_o     = entry_q;
  assign pc_load_o   = load_q;
  assign next_pc_o   = npc_q;
  assign saved_psr_o = spsr_q;
  assign save_mode_o = smode_q;
  assign link_o      = link_q;
  assign exc_id_o    = id_q;

  // R5
  entry_loads_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_q |-> load_q);

  // R6
  entry_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_q |-> (psr_q[BIT_I] && !psr_q[BIT_T] && !psr_q[BIT_J]
                 && psr_q[MODE_W-1:0] == smode_q));

  // R4
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_q |-> (npc_q[1:0] == 2'b00));

  // R9
  user_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_req_i && !ret_req_i && exc_req_i == '0 && psr_q[MODE_W-1:0] == MODE_USR)
    |=> (psr_q[23:0] == $past(psr_q[23:0])));

  // R7
  return_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req_i && exc_req_i == '0)
    |=> (psr_q == $past(ret_psr_i) && load_q && !entry_q && npc_q == $past(ret_addr_i)));
endmodule

// File: tb/pstat_trap_unit_tb.sv
module pstat_trap_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  exc_req = '0;
  logic        hi_vec = 1'b0;
  logic [31:0] pc = '0;
  logic        ret_req = 1'b0;
  logic [31:0] ret_psr = '0, ret_addr = '0;
  logic        mv_req = 1'b0;
  logic [3:0]  mv_mask = '0;
  logic [31:0] mv_data = '0;
  logic [31:0] psr, next_pc, saved_psr, link;
  logic        entry, pc_load;
  logic [4:0]  save_mode;
  logic [2:0]  exc_id;

  always #2 clk = ~clk;

  pstat_trap_unit dut_i (
    .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req), .hi_vec_i(hi_vec), .pc_i(pc),
    .ret_req_i(ret_req), .ret_psr_i(ret_psr), .ret_addr_i(ret_addr),
    .mv_req_i(mv_req), .mv_mask_i(mv_mask), .mv_data_i(mv_data),
    .psr_o(psr), .entry_o(entry), .pc_load_o(pc_load), .next_pc_o(next_pc),
    .saved_psr_o(saved_psr), .save_mode_o(save_mode), .link_o(link), .exc_id_o(exc_id)
  );

  typedef struct packed {
    logic [31:0] psr;
    logic        entry;
    logic        load;
    logic [31:0] npc;
    logic [31:0] spsr;
    logic [31:0] lr;
    logic [4:0]  smode;
    logic [2:0]  id;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    total = 0;
  int    bad = 0;
  bit    finished = 1'b0;

  // reference state built from the requirements
  exp_t m;

  function automatic logic [31:0] offset_of(input int k); // R4 offsets
    case (k)
      0: return 32'h00; 1: return 32'h04; 2: return 32'h08; 3: return 32'h0C;
      4: return 32'h10; 5: return 32'h18; default: return 32'h1C;
    endcase
  endfunction

  function automatic logic [4:0] mode_of(input int k); // R6 modes
    case (k)
      0, 2: return 5'b10011; 1: return 5'b11011; 3, 4: return 5'b10111;
      5: return 5'b10010; default: return 5'b10001;
    endcase
  endfunction

  task automatic model_step(input logic [6:0] rq, input logic hv, input logic rt,
                            input logic [31:0] rps, input logic [31:0] ra,
                            input logic mv, input logic [3:0] mk,
                            input logic [31:0] md, input logic [31:0] pcv);
    logic [6:0] live;
    int order[7];
    int win;
    order = '{0, 4, 6, 5, 3, 1, 2}; // R2 order
    live = rq;
    if (m.psr[7]) live[5] = 1'b0;   // R3
    if (m.psr[6]) live[6] = 1'b0;   // R3
    win = -1;
    for (int r = 0; r < 7; r++) if (win < 0 && live[order[r]]) win = order[r];
    m.entry = 1'b0;
    m.load  = 1'b0;
    if (win >= 0) begin              // R10 exception first
      m.entry = 1'b1;
      m.load  = 1'b1;
      m.spsr  = m.psr;
      m.lr    = pcv;
      m.smode = mode_of(win);
      m.id    = 3'(win);
      m.npc   = (hv ? 32'hFFFF_0000 : 32'h0) + offset_of(win);
      m.psr[5] = 1'b0;
      m.psr[24] = 1'b0;
      m.psr[7] = 1'b1;
      if (win == 0 || win == 6) m.psr[6] = 1'b1;
      m.psr[4:0] = mode_of(win);
    end else if (rt) begin
      m.load = 1'b1;
      m.psr  = rps;
      m.npc  = ra;
    end else if (mv) begin
      for (int b = 0; b < 4; b++)
        if (mk[b] && (m.psr[4:0] != 5'b10000 || b == 3)) m.psr[b*8 +: 8] = md[b*8 +: 8];
    end
  endtask

  task automatic drive(input string tag, input logic [6:0] rq, input logic hv,
                       input logic rt, input logic [31:0] rps, input logic [31:0] ra,
                       input logic mv, input logic [3:0] mk, input logic [31:0] md,
                       input logic [31:0] pcv);
    @(negedge clk);
    exc_req = rq; hi_vec = hv; ret_req = rt; ret_psr = rps; ret_addr = ra;
    mv_req = mv; mv_mask = mk; mv_data = md; pc = pcv;
    model_step(rq, hv, rt, rps, ra, mv, mk, md, pcv);
    exp_q.push_back(m);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    drive(tag, 7'h0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 4'h0, 32'h0, 32'h0);
  endtask

  task automatic mv_op(input string tag, input logic [3:0] mk, input logic [31:0] md);
    drive(tag, 7'h0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, mk, md, 32'h0);
  endtask

  task automatic exc_op(input string tag, input logic [6:0] rq, input logic hv,
                        input logic [31:0] pcv);
    drive(tag, rq, hv, 1'b0, 32'h0, 32'h0, 1'b0, 4'h0, 32'h0, pcv);
  endtask

  // monitor: compare one expected item per clock
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t  e;
        exp_t  a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = '{psr: psr, entry: entry, load: pc_load, npc: next_pc, spsr: saved_psr,
              lr: link, smode: save_mode, id: exc_id};
        total++;
        if (a !== e) begin
          bad++;
          $display("FAIL %s act psr=%h en=%b ld=%b pc=%h sv=%h lr=%h md=%b id=%0d exp psr=%h en=%b ld=%b pc=%h sv=%h lr=%h md=%b id=%0d",
                   t, a.psr, a.entry, a.load, a.npc, a.spsr, a.lr, a.smode, a.id,
                   e.psr, e.entry, e.load, e.npc, e.spsr, e.lr, e.smode, e.id);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m = '0;
    m.psr = 32'h0000_00D3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (psr !== 32'h0000_00D3 || entry !== 1'b0 || pc_load !== 1'b0 || next_pc !== 32'h0) begin
      bad++;
      $display("FAIL R1 reset act psr=%h en=%b ld=%b exp psr=000000d3 en=0 ld=0", psr, entry, pc_load);
    end
    idle("R1 idle");
    mv_op("R8 control byte only", 4'b0001, 32'hABCD_EF1F);
    mv_op("R8 flag byte only", 4'b1000, 32'hF000_0000);
    mv_op("R8 mask zero writes nothing", 4'b0000, 32'h1234_5678);
    mv_op("R8 drop to user", 4'b0001, 32'h0000_0010);
    mv_op("R9 user move full mask", 4'b1111, 32'h0F0F_0FD3);
    mv_op("R9 user move without flag bit", 4'b0111, 32'hFFFF_FFFF);
    exc_op("R4 R5 R6 interrupt entry", 7'b010_0000, 1'b0, 32'h0000_1000);
    exc_op("R3 interrupt while disabled", 7'b010_0000, 1'b0, 32'h0000_1004);
    exc_op("R6 fast interrupt entry", 7'b100_0000, 1'b0, 32'h0000_2000);
    exc_op("R3 fast interrupt while disabled", 7'b110_0000, 1'b0, 32'h0000_2004);
    drive("R7 return restores", 7'h0, 1'b0, 1'b1, 32'h2100_0030, 32'h0000_2004,
          1'b0, 4'h0, 32'h0, 32'h0);
    exc_op("R2 data abort beats rest", 7'b011_1110, 1'b0, 32'h0000_3000);
    exc_op("R2 R4 high base fetch abort", 7'b010_1010, 1'b1, 32'h0000_3004);
    drive("R10 exception over return and move", 7'b000_0010, 1'b0, 1'b1, 32'h0000_0010,
          32'h0000_5000, 1'b1, 4'b1111, 32'h0, 32'h0000_4000);
    drive("R10 return over move", 7'h0, 1'b0, 1'b1, 32'h6000_001F, 32'h0000_6000,
          1'b1, 4'b1111, 32'hFFFF_FFFF, 32'h0);
    mv_op("R8 system mode clears masks and sets J", 4'b1001, 32'h0100_001F);
    exc_op("R2 R6 software trap keeps F", 7'b000_0100, 1'b0, 32'h0000_7000);
    mv_op("R8 clear masks again", 4'b0001, 32'h0000_001F);
    exc_op("R2 fast interrupt over interrupt and undefined", 7'b110_0010, 1'b1, 32'h0000_8000);
    exc_op("R2 R6 reset request wins", 7'b111_1111, 1'b0, 32'h0000_9000);
    exc_op("R2 undefined over software trap", 7'b000_0110, 1'b0, 32'h0000_A000);
    idle("R5 pulse ends");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule